// File: doc/BRIEF.md
# External Data Access Stretch Timer

This block times read and write cycles to external data memory. A requester raises a one-clock request together with a direction flag, a target flag (external or internal), an address, write data and a 3-bit stretch setting. The timer latches the operands, then runs the access for a whole number of machine cycles. A machine cycle is a fixed number of oscillator clocks, set by a parameter.

For external accesses the stretch setting picks one of eight access lengths, from 2 to 12 machine cycles. The read or write strobe is held for every machine cycle of the access except the first and the last. Those two cycles give address setup and hold time. Read data from the bus is captured into an output register just before the read strobe falls.

Internal accesses ignore the stretch setting, drive no strobe and always take the minimum length. Every access ends with a one-clock done pulse. Requests that arrive while an access is running are dropped.

Top module: `xmem_stretch_timer`

## Requirements
- R1: While and directly after synchronous reset, `rd_en_o`, `wr_en_o` and `done_o` are low and `addr_o`, `wdata_o` and `rdata_o` are zero.
- R2: An access accepted at a clock edge lasts L machine cycles. For an external access L is `stretch_i + 2` when `stretch_i` is 0 to 6, and 12 when it is 7. For an internal access L is 2. `done_o` is high for exactly the one clock that follows the last clock of the access.
- R3: One machine cycle spans `CLKS_PER_MC` clocks, counted from the first clock after the accepting edge.
- R4: During an external read (`wr_i`=0), `rd_en_o` is high in every machine cycle except the first and the last, and `wr_en_o` stays low.
- R5: During an external write (`wr_i`=1), `wr_en_o` is high in every machine cycle except the first and the last, and `rd_en_o` stays low.
- R6: An external read loads `rdata_o` from `rd_data_i` at the final clock of the second-to-last machine cycle. `rdata_o` then holds that value until the next external read loads it.
- R7: An internal access (`ext_i`=0) takes 2 machine cycles whatever the stretch setting. It raises neither strobe and leaves `rdata_o` unchanged.
- R8: `addr_o` and `wdata_o` take `addr_i` and `wdata_i` at the accepting edge and hold them through the access.
- R9: A request while an access runs, including in its last clock, is ignored. The operands, strobes and done timing of the running access are unaffected, and no second access follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, sampled while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| ext_i | input | 1 | 1 = external data memory, 0 = internal |
| stretch_i | input | 3 | Stretch setting, selects the access length |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| rd_data_i | input | DATA_W | Read data from the external bus |
| rd_en_o | output | 1 | External read strobe enable |
| wr_en_o | output | 1 | External write strobe enable |
| addr_o | output | ADDR_W | Latched address driven to memory |
| wdata_o | output | DATA_W | Latched write data driven to memory |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-clock end-of-access pulse |

## Verification
The bench builds the timer with `CLKS_PER_MC` = 3 and a 16-bit address. A prescaler limit that is not a power of two shows any off-by-one in the machine-cycle count directly. The longest access, 36 clocks, stays short enough to check every clock of every setting.

The bench drives a different value on `rd_data_i` in each clock. The captured byte therefore shows the exact capture clock.

Extra requests are placed mid-access and in the final clock. This exercises the boundary where the timer is about to go idle but must not yet accept.

// File: rtl/xmem_stretch_pkg.sv
package xmem_stretch_pkg;
  localparam int SET_W = 3;
  localparam int LEN_W = 4;
  localparam logic [LEN_W-1:0] MIN_LEN = 4'd2;

  // Machine cycles for each stretch setting; the top setting jumps to 12.
  function automatic logic [LEN_W-1:0] mc_len(input logic [SET_W-1:0] s);
    if (s == 3'd7) return 4'd12;
    return 4'(s) + MIN_LEN;
  endfunction
endpackage

// File: rtl/xmem_mc_tick.sv
module xmem_mc_tick #(
  parameter int CLKS_PER_MC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic mc_end
);
  localparam int CC_W = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
  localparam logic [CC_W-1:0] LAST = CC_W'(CLKS_PER_MC - 1);

  logic [CC_W-1:0] cc;

  always_ff @(posedge clk) begin
    if (rst || start) cc <= '0;
    else if (run) cc <= (cc == LAST) ? '0 : cc + 1'b1;
  end

  assign mc_end = run && (cc == LAST);

  assert_cc_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cc <= LAST);
  assert_cc_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> $stable(cc));
endmodule

// File: rtl/xmem_access_seq.sv
module xmem_access_seq
  import xmem_stretch_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ext,
  input  logic             wr,
  input  logic [SET_W-1:0] setting,
  input  logic             mc_end,
  output logic             busy,
  output logic             done,
  output logic             rd_en,
  output logic             wr_en,
  output logic             capture
);
  logic [LEN_W-1:0] mc;
  logic [LEN_W-1:0] total;
  logic             ext_q;
  logic             wr_q;
  logic             last_mc;
  logic             strobe_next;

  assign last_mc     = (mc == total - 4'd1);
  assign strobe_next = ext_q && ((mc + 4'd1) < (total - 4'd1));
  assign capture     = busy && ext_q && !wr_q && mc_end && (mc == total - 4'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      rd_en <= 1'b0;
      wr_en <= 1'b0;
      mc    <= '0;
      total <= MIN_LEN;
      ext_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        mc    <= '0;
        total <= ext ? mc_len(setting) : MIN_LEN;
        ext_q <= ext;
        wr_q  <= wr;
        rd_en <= 1'b0;
        wr_en <= 1'b0;
      end else if (busy && mc_end) begin
        if (last_mc) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          rd_en <= 1'b0;
          wr_en <= 1'b0;
        end else begin
          mc    <= mc + 4'd1;
          rd_en <= strobe_next && !wr_q;
          wr_en <= strobe_next && wr_q;
        end
      end
    end
  end

  assert_mc_range_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (mc < total));
  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));
  assert_strobe_inside_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en || wr_en) |-> busy);
  assert_int_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !ext_q) |-> !(rd_en || wr_en));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/xmem_stretch_timer.sv
module xmem_stretch_timer
  import xmem_stretch_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 8,
  parameter int CLKS_PER_MC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              ext_i,
  input  logic [SET_W-1:0]  stretch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  logic busy;
  logic start;
  logic mc_end;
  logic capture;

  assign start = req_i && !busy;

  xmem_mc_tick #(.CLKS_PER_MC(CLKS_PER_MC)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .run    (busy),
    .mc_end (mc_end)
  );

  xmem_access_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ext     (ext_i),
    .wr      (wr_i),
    .setting (stretch_i),
    .mc_end  (mc_end),
    .busy    (busy),
    .done    (done_o),
    .rd_en   (rd_en_o),
    .wr_en   (wr_en_o),
    .capture (capture)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
    end else begin
      if (start) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
      if (capture) rdata_o <= rd_data_i;
    end
  end

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(addr_o));
  assert_wdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(wdata_o));
  assert_rdata_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (!rd_en_o && !busy) |=> $stable(rdata_o));
endmodule

// File: tb/test_xmem_stretch_timer.sv
module test_xmem_stretch_timer;
  localparam int C  = 3;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          wr = 1'b0;
  logic          ext = 1'b0;
  logic [2:0]    stretch = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_bus = '0;
  logic          rd_en, wr_en, done;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata;

  int nchk  = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  xmem_stretch_timer #(.ADDR_W(AW), .DATA_W(DW), .CLKS_PER_MC(C)) i_xmem_stretch_timer (
    .clk(clk), .rst(rst), .req_i(req), .wr_i(wr), .ext_i(ext),
    .stretch_i(stretch), .addr_i(addr), .wdata_i(wdata), .rd_data_i(rd_bus),
    .rd_en_o(rd_en), .wr_en_o(wr_en), .addr_o(addr_q), .wdata_o(wdata_q),
    .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // One access, checked clock by clock; inj >= 0 injects a stray request at that index.
  task automatic run_access(input logic e, input logic w, input logic [2:0] s,
                            input logic [AW-1:0] a, input logic [DW-1:0] d, input int inj);
    int total;
    int n;
    logic [DW-1:0] prev;
    total = e ? ((s == 3'd7) ? 12 : int'(s) + 2) : 2;
    n = total * C;
    prev = rdata;
    @(negedge clk);
    req = 1'b1; ext = e; wr = w; stretch = s; addr = a; wdata = d;
    @(negedge clk);
    for (int k = 0; k <= n + 1; k++) begin
      rd_bus = 8'hA0 ^ 8'(k);
      if (k == inj) begin
        req = 1'b1; ext = 1'b1; wr = ~w; stretch = 3'd0; addr = ~a; wdata = ~d;
      end else begin
        req = 1'b0;
      end
      chk(w ? "R5" : "R4", $sformatf("rd_en idx %0d", k), int'(rd_en),
          int'(e && !w && k >= C && k < (total - 1) * C));
      chk(w ? "R5" : "R4", $sformatf("wr_en idx %0d", k), int'(wr_en),
          int'(e && w && k >= C && k < (total - 1) * C));
      chk((inj >= 0) ? "R9" : "R2", $sformatf("done idx %0d", k), int'(done), int'(k == n));
      if (k <= n) begin
        chk("R8", $sformatf("addr idx %0d", k), int'(addr_q), int'(a));
        chk("R8", $sformatf("wdata idx %0d", k), int'(wdata_q), int'(d));
      end
      if (k == n) begin
        if (e && !w)
          chk("R6", "captured read data", int'(rdata), int'(8'hA0 ^ 8'((total - 1) * C - 1)));
        else
          chk(e ? "R6" : "R7", "read data unchanged", int'(rdata), int'(prev));
      end
      @(negedge clk);
    end
    req = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "rd_en in reset", int'(rd_en), 0);
    chk("R1", "wr_en in reset", int'(wr_en), 0);
    chk("R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "addr after reset", int'(addr_q), 0);
    chk("R1", "wdata after reset", int'(wdata_q), 0);
    chk("R1", "rdata after reset", int'(rdata), 0);
  endtask

  task automatic t_ext_reads();   // R2 R3 R4 R6: every setting
    for (int s = 0; s < 8; s++)
      run_access(1'b1, 1'b0, 3'(s), 16'h1200 + 16'(s), 8'h30 + 8'(s), -1);
  endtask

  task automatic t_ext_writes();  // R5, R6 hold across writes
    run_access(1'b1, 1'b1, 3'd0, 16'hBEEF, 8'h5A, -1);
    run_access(1'b1, 1'b1, 3'd3, 16'hCAFE, 8'hC3, -1);
    run_access(1'b1, 1'b1, 3'd7, 16'h0F0F, 8'h99, -1);
  endtask

  task automatic t_internal();    // R7
    run_access(1'b0, 1'b0, 3'd7, 16'h0042, 8'h11, -1);
    run_access(1'b0, 1'b1, 3'd5, 16'h0043, 8'h22, -1);
  endtask

  task automatic t_busy_ignore(); // R9: mid-access and final clock
    run_access(1'b1, 1'b0, 3'd4, 16'h7777, 8'h44, 4);
    run_access(1'b1, 1'b1, 3'd2, 16'h8888, 8'h55, 4 * C - 1);
    run_access(1'b0, 1'b0, 3'd6, 16'h9999, 8'h66, 2 * C - 1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R2 watchdog actual=hang expected=finish");
    summary();
  end

  initial begin
    t_reset();
    t_ext_reads();
    t_ext_writes();
    t_internal();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule